// File: doc/BRIEF.md
# GPIO Port with Per-Pin Configuration

This block is a port of general-purpose pins, 32 by default, controlled through a simple word-addressed register bus. Software sets the pin directions, drives output levels and reads the resolved input levels. Each pin also has its own configuration word. That word holds the pin's direction, an input-buffer disconnect bit and a pull selection. The direction bit is stored only once. The port-wide direction register and bit 0 of each pin's configuration word are two views of that same bit.

Outside the block, each pad reports a level and whether something external is driving it. Each clock, the block computes the value it will latch for every pin:
- A disconnected buffer reads 0.
- An output pin reads back its own level.
- A driven input follows the external level.
- A floating input takes its pull value, or keeps its last value when no pull is selected.

When an output pin and an external driver disagree, the block records a short-circuit as a sticky per-pin fault. Software clears a fault by writing 1 to its bit.

Top module: `gpio_port`

## Requirements
- R1: After reset, the out, out-set, out-clear, input, direction, direction-set, direction-clear and fault words (word addresses 0 to 7) all read 0, and `pad_oe`, `pad_out` and `fault_o` are 0.
- R2: After reset, every pin configuration word (word address 32 + pin) reads 0x00000002.
- R3: A write to direction-set (address 5) sets the masked direction bits. A write to direction-clear (6) clears them. A write to direction (4) replaces the whole register. Bit 0 of each pin's configuration word always equals that pin's direction bit, and `pad_oe` equals the direction register.
- R4: The configuration word has these fields: bit 0 is the direction (1 = output), bit 1 set disconnects the input buffer, and bits 3:2 select the pull (3 = up, 1 = down, 0 or 2 = none). It reads back those four bits, with all upper bits 0.
- R5: For a connected input pin, the input register (address 3) takes the external level one clock after the pad is sampled while driven. While the pad floats with no pull selected, the last value is kept.
- R6: A connected, floating input pin reads 1 with pull-up and 0 with pull-down.
- R7: A write to out (0) replaces the output register. Out-set (1) sets the masked bits and out-clear (2) clears them. `pad_out` shows the output register, and the set and clear words read back the output register.
- R8: A connected output pin latches its own driven level into the input register, whatever the external level.
- R9: When a pin is an output, its pad is externally driven, and the two levels differ, the pin's fault bit (address 7) is set on the next clock. `fault_o` is the OR of all fault bits.
- R10: Fault bits stay set until cleared by writing 1 to the bit. A pin whose clash persists in the cycle of the clearing write stays set.
- R11: A pin whose input buffer is disconnected reads 0 in the input register.
- R12: Writes to the input register, and to unmapped addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational; 0 when not selected |
| pad_in | input | NPINS | External pad levels |
| pad_drv | input | NPINS | 1 = pad externally driven, 0 = floating |
| pad_out | output | NPINS | Output levels |
| pad_oe | output | NPINS | Output enables (direction) |
| fault_o | output | 1 | At least one sticky contention bit is set |

## Verification
Errors in the state fall into two groups, and they differ in how quickly they show.

A wrong direction or output bit shows on `pad_oe` or `pad_out` in the cycle after the write. The same applies to a direction alias that fails to update the configuration view.

A wrong input hold, pull or loopback decision is only visible through the input register. It shows one clock after the pad sample that caused it, but only once the bench reads that address. For this reason the reference model is compared on every clock, with random addresses, so that a stale held level is caught within a few reads. A lost or phantom fault bit shows on `fault_o` one clock after the clash.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b11;

    typedef enum logic [2:0] {
        REG_OUT    = 3'd0,
        REG_OUTSET = 3'd1,
        REG_OUTCLR = 3'd2,
        REG_IN     = 3'd3,
        REG_DIR    = 3'd4,
        REG_DIRSET = 3'd5,
        REG_DIRCLR = 3'd6,
        REG_FAULT  = 3'd7
    } port_reg_e;

    typedef struct packed {
        logic out_wr;
        logic out_set;
        logic out_clr;
        logic dir_wr;
        logic dir_set;
        logic dir_clr;
        logic fault_clr;
        logic cfg_wr;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        stb_o,
    output logic              is_cfg_o,
    output logic              is_port_o,
    output port_reg_e         reg_sel_o,
    output logic [ADDR_W-2:0] cfg_idx_o
);
    localparam int NPORTREGS = 8;

    logic wr_port;

    always_comb begin
        is_cfg_o  = addr_i[ADDR_W-1];
        is_port_o = (addr_i < ADDR_W'(NPORTREGS));
        reg_sel_o = port_reg_e'(addr_i[2:0]);
        cfg_idx_o = addr_i[ADDR_W-2:0];
        wr_port   = sel_i && wr_i && is_port_o;

        stb_o           = '0;
        stb_o.out_wr    = wr_port && (reg_sel_o == REG_OUT);
        stb_o.out_set   = wr_port && (reg_sel_o == REG_OUTSET);
        stb_o.out_clr   = wr_port && (reg_sel_o == REG_OUTCLR);
        stb_o.dir_wr    = wr_port && (reg_sel_o == REG_DIR);
        stb_o.dir_set   = wr_port && (reg_sel_o == REG_DIRSET);
        stb_o.dir_clr   = wr_port && (reg_sel_o == REG_DIRCLR);
        stb_o.fault_clr = wr_port && (reg_sel_o == REG_FAULT);
        stb_o.cfg_wr    = sel_i && wr_i && is_cfg_o;
    end

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
    import gpio_port_pkg::*;
(
    input  logic       dir_i,
    input  logic       disc_i,
    input  logic [1:0] pull_i,
    input  logic       out_i,
    input  logic       ext_lvl_i,
    input  logic       ext_drv_i,
    input  logic       hold_i,
    output logic       in_nxt_o,
    output logic       clash_o
);
    always_comb begin
        clash_o = dir_i && ext_drv_i && (ext_lvl_i != out_i);
        if (disc_i) begin
            in_nxt_o = 1'b0;
        end else if (dir_i) begin
            in_nxt_o = out_i;
        end else if (ext_drv_i) begin
            in_nxt_o = ext_lvl_i;
        end else begin
            case (pull_i)
                PULL_UP:   in_nxt_o = 1'b1;
                PULL_DOWN: in_nxt_o = 1'b0;
                default:   in_nxt_o = hold_i;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = $clog2(NPINS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  pad_drv,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              fault_o
);
    typedef struct packed {
        logic [NPINS-1:0]   out;
        logic [NPINS-1:0]   dir;
        logic [NPINS-1:0]   disc;
        logic [NPINS-1:0]   in;
        logic [NPINS-1:0]   fault;
        logic [2*NPINS-1:0] pull;
    } state_t;

    state_t            st_d, st_q;
    wr_strobe_t        stb;
    logic              is_cfg, is_port;
    port_reg_e         reg_sel;
    logic [ADDR_W-2:0] cfg_idx;
    logic [NPINS-1:0]  in_nxt, clash, wd;

    assign wd = bus_wdata[NPINS-1:0];

    gpio_port_decode #(.ADDR_W(ADDR_W)) decode_i (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .stb_o     (stb),
        .is_cfg_o  (is_cfg),
        .is_port_o (is_port),
        .reg_sel_o (reg_sel),
        .cfg_idx_o (cfg_idx)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_port_pin pin_i (
            .dir_i     (st_q.dir[i]),
            .disc_i    (st_q.disc[i]),
            .pull_i    (st_q.pull[2*i +: 2]),
            .out_i     (st_q.out[i]),
            .ext_lvl_i (pad_in[i]),
            .ext_drv_i (pad_drv[i]),
            .hold_i    (st_q.in[i]),
            .in_nxt_o  (in_nxt[i]),
            .clash_o   (clash[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.in    = in_nxt;
        st_d.fault = (st_q.fault & ~(stb.fault_clr ? wd : '0)) | clash;
        if (stb.out_wr)  st_d.out = wd;
        if (stb.out_set) st_d.out = st_q.out | wd;
        if (stb.out_clr) st_d.out = st_q.out & ~wd;
        if (stb.dir_wr)  st_d.dir = wd;
        if (stb.dir_set) st_d.dir = st_q.dir | wd;
        if (stb.dir_clr) st_d.dir = st_q.dir & ~wd;
        if (stb.cfg_wr) begin
            st_d.dir[cfg_idx]          = bus_wdata[0];
            st_d.disc[cfg_idx]         = bus_wdata[1];
            st_d.pull[2*cfg_idx +: 2]  = bus_wdata[3:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.disc <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (is_cfg) begin
                bus_rdata = DW'({st_q.pull[2*cfg_idx +: 2],
                                 st_q.disc[cfg_idx], st_q.dir[cfg_idx]});
            end else if (is_port) begin
                case (reg_sel)
                    REG_OUT, REG_OUTSET, REG_OUTCLR: bus_rdata = DW'(st_q.out);
                    REG_IN:                          bus_rdata = DW'(st_q.in);
                    REG_DIR, REG_DIRSET, REG_DIRCLR: bus_rdata = DW'(st_q.dir);
                    default:                         bus_rdata = DW'(st_q.fault);
                endcase
            end
        end
    end

    assign pad_out = st_q.out;
    assign pad_oe  = st_q.dir;
    assign fault_o = |st_q.fault;

    // R3: masked bits are enabled as outputs after a direction-set write
    p_dirset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb.dir_set |=> ((pad_oe & $past(wd)) == $past(wd)));

    // R3: masked bits are released after a direction-clear write
    p_dirclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb.dir_clr |=> ((pad_oe & $past(wd)) == '0));

    // R7: out-set raises every masked pad
    p_outset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb.out_set |=> ((pad_out & $past(wd)) == $past(wd)));

    // R11: disconnected buffers latch 0
    p_disc_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.in & $past(st_q.disc)) == '0));

    // R9: a clash at the pads raises the fault output next cycle
    p_fault_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pad_oe & pad_drv & (pad_in ^ pad_out))) |=> fault_o);

    // R10: the fault output holds until a clearing write
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !stb.fault_clr) |=> fault_o);

endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0, pad_drv = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          fault_o;

    int n_vec = 0;
    int n_fail = 0;
    logic [31:0] rv;

    // reference model state
    logic [31:0] m_out, m_dir, m_disc, m_in, m_cont;
    logic [1:0]  m_pull [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_drv(pad_drv), .pad_out(pad_out),
        .pad_oe(pad_oe), .fault_o(fault_o)
    );

    task automatic model_reset();
        m_out = 0; m_dir = 0; m_disc = '1; m_in = 0; m_cont = 0;
        for (int i = 0; i < N; i++) m_pull[i] = 2'd0;
    endtask

    function automatic logic [31:0] model_read(int a);
        if (!bus_sel) return 0;
        if (a >= 32)
            return {28'd0, m_pull[a-32], m_disc[a-32], m_dir[a-32]};
        case (a)
            0, 1, 2: return m_out;
            3:       return m_in;
            4, 5, 6: return m_dir;
            7:       return m_cont;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] nin, nclash;
        int a;
        a = int'(bus_addr);
        for (int i = 0; i < N; i++) begin
            nclash[i] = m_dir[i] && pad_drv[i] && (pad_in[i] != m_out[i]);
            if (m_disc[i])         nin[i] = 1'b0;
            else if (m_dir[i])     nin[i] = m_out[i];
            else if (pad_drv[i])   nin[i] = pad_in[i];
            else if (m_pull[i] == 2'd3) nin[i] = 1'b1;
            else if (m_pull[i] == 2'd1) nin[i] = 1'b0;
            else                   nin[i] = m_in[i];
        end
        if (bus_sel && bus_wr && a == 7) m_cont = m_cont & ~bus_wdata;
        m_cont = m_cont | nclash;
        if (bus_sel && bus_wr) begin
            if (a >= 32) begin
                m_dir[a-32]  = bus_wdata[0];
                m_disc[a-32] = bus_wdata[1];
                m_pull[a-32] = bus_wdata[3:2];
            end else begin
                case (a)
                    0: m_out = bus_wdata;
                    1: m_out = m_out | bus_wdata;
                    2: m_out = m_out & ~bus_wdata;
                    4: m_dir = bus_wdata;
                    5: m_dir = m_dir | bus_wdata;
                    6: m_dir = m_dir & ~bus_wdata;
                    default: ;
                endcase
            end
        end
        m_in = nin;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int a);
        if (a >= 32) return "R4 cfg readback";
        case (a)
            0, 1, 2: return "R7 out readback";
            3:       return "R5 input readback";
            4, 5, 6: return "R3 dir readback";
            7:       return "R10 fault readback";
            default: return "R12 unmapped read";
        endcase
    endfunction

    task automatic compare_all();
        check(bus_rdata, model_read(int'(bus_addr)), tag_of(int'(bus_addr)));
        check(32'(pad_oe), m_dir, "R3 pad_oe");
        check(32'(pad_out), m_out, "R7 pad_out");
        check(32'(fault_o), 32'(|m_cont), "R9 fault_o");
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        compare_all();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
        #1;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: port words and pads after reset
        for (int a = 0; a < 8; a++) begin
            rd(a, rv); check(rv, 32'h0, "R1 reset word");
        end
        check(32'(pad_oe), 0, "R1 pad_oe");
        check(32'(pad_out), 0, "R1 pad_out");
        check(32'(fault_o), 0, "R1 fault_o");
        // R2: configuration words after reset
        for (int p = 0; p < N; p++) begin
            rd(32 + p, rv); check(rv, 32'h2, "R2 cfg reset");
        end
        // R3: aliases and the shared direction bit
        wr(5, 32'h8000_0001);
        rd(4, rv);  check(rv, 32'h8000_0001, "R3 dirset");
        rd(32, rv); check(rv & 1, 1, "R3 cfg0 dir");
        rd(63, rv); check(rv & 1, 1, "R3 cfg31 dir");
        wr(6, 32'h8000_0001);
        rd(4, rv);  check(rv, 0, "R3 dirclr");
        rd(63, rv); check(rv & 1, 0, "R3 cfg31 dir");
        wr(4, 32'h8000_0001);
        rd(32, rv); check(rv & 1, 1, "R3 dir write");
        wr(4, 0);
        // R12: input register ignores writes
        wr(3, 32'hFFFF_FFFF); step();
        rd(3, rv); check(rv, 0, "R12 input write ignored");
        wr(20, 32'hFFFF_FFFF);
        rd(0, rv); check(rv, 0, "R12 unmapped write ignored");
        // R5: driven input follows, floating keeps
        pad_drv[0] = 1; pad_in[0] = 0;
        wr(32, 0); step();
        rd(3, rv); check(rv & 1, 0, "R5 follows low");
        pad_in[0] = 1; step();
        rd(3, rv); check(rv & 1, 1, "R5 follows high");
        pad_drv[0] = 0; pad_in[0] = 0; step(); step();
        rd(3, rv); check(rv & 1, 1, "R5 floating holds");
        // R6: pulls on a floating pin
        wr(32, 32'b0100); step();
        rd(3, rv); check(rv & 1, 0, "R6 pull-down");
        wr(32, 32'b1100); step();
        rd(3, rv); check(rv & 1, 1, "R6 pull-up");
        rd(32, rv); check(rv, 32'hC, "R4 cfg fields");
        // R7: output set and clear
        wr(32, 32'b0011);
        wr(1, 1);
        check(32'(pad_out[0]), 1, "R7 outset pad");
        check(32'(pad_oe[0]), 1, "R7 oe");
        // R11: disconnected output reads 0
        step();
        rd(3, rv); check(rv & 1, 0, "R11 disconnected");
        wr(2, 1);
        check(32'(pad_out[0]), 0, "R7 outclr pad");
        // R8: loopback
        wr(32, 32'b0001); wr(1, 1); step();
        rd(3, rv); check(rv & 1, 1, "R8 loopback high");
        wr(2, 1); step();
        rd(3, rv); check(rv & 1, 0, "R8 loopback low");
        // R9: contention
        pad_drv[0] = 1; pad_in[0] = 1; step();
        check(32'(fault_o), 1, "R9 fault raised");
        rd(7, rv); check(rv & 1, 1, "R9 fault bit");
        // R10: set wins while clash persists, then clear
        wr(7, 1);
        check(32'(fault_o), 1, "R10 set wins over clear");
        pad_drv[0] = 0; step();
        check(32'(fault_o), 1, "R10 sticky");
        wr(7, 1);
        check(32'(fault_o), 0, "R10 cleared");
        // random traffic against the model
        for (int k = 0; k < 6000; k++) begin
            bus_sel   = 1'($urandom);
            bus_wr    = ($urandom % 4) == 0;
            bus_addr  = AW'($urandom);
            bus_wdata = $urandom;
            pad_in    = N'($urandom);
            pad_drv   = N'($urandom);
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule